// File: doc/BRIEF.md
# Command-Addressed Two-Wire Register Slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line). It samples both lines on a fast system clock, finds START and STOP conditions, and compares the first byte of each transfer with a 7-bit address. The top six bits of that address are a parameter. The lowest bit comes from a strap input. After it acknowledges a write address, the block takes a command byte that names one register.

The master then writes one data byte to that register, or it issues a repeated START and reads the register back. Three registers can be read and written: a divider select, a control register and a tuning offset. These drive the block's outputs directly. A fourth command reads a 10-bit temperature code as two bytes, with the high byte first. That code is captured from a separate conversion source whenever it flags a finished result.

The bus pins and the register outputs are plain level signals. Data moves only under the master's clock, so there is no valid/ready handshake: the block never applies back-pressure, because clock stretching is not implemented. The data line is driven only through an active-high pull-low enable.

Top module: `cmdslv_top`

## Requirements
- R1: The address byte matches when its upper seven bits equal `100010` followed by the strap input. The slave then pulls SDA low in the ninth clock, whether bit 0 (R/W, 1 = read) is 0 or 1. On a mismatch it does not acknowledge and ignores the bus until the next START.
- R2: The command codes are 5Dh (divider select), 60h (control), 64h (temperature) and 66h (tuning), and each is acknowledged. Any other code is not acknowledged, and the rest of that transfer is ignored.
- R3: In a write transfer, the data byte after a divider, control or tuning command is acknowledged. It reaches the matching output once the acknowledge clock begins.
- R4: Only one data byte is taken per command. A second data byte in the same write is not acknowledged and changes no register.
- R5: A read transfer returns the register named by the most recent command, MSB first. The command is kept across a repeated START. For a one-byte register, any further byte the master acknowledges reads as FFh (line released).
- R6: A temperature read returns the code as `code[9:2]` and then `{code[1:0], 000000}`. Both bytes come from the same captured value, even when a new conversion finishes between them. A third byte reads FFh.
- R7: The temperature value used for reads changes only in a cycle where `temp_valid_i` is high. A new code presented without that strobe is not reported.
- R8: After the master answers a read byte with NACK, the slave releases SDA and waits for the next START.
- R9: The control register keeps only its low four bits. Its upper four bits read back and drive out as zero.
- R10: A START or STOP in any state, including partway through a byte, discards the byte in progress. A STOP during a data byte leaves the register unchanged, and a START begins a new address phase.
- R11: The slave changes its SDA drive only while SCL is low. Data it drives holds for the whole SCL high time.
- R12: After reset, all register outputs are zero and SDA is released.
- R13: A data byte written after the temperature command is acknowledged and has no effect on the temperature read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap_i | input | 1 | Supplies bit 0 of the 7-bit slave address |
| temp_code_i | input | 10 | Two's complement temperature in quarter degrees |
| temp_valid_i | input | 1 | One-cycle strobe: temp_code_i holds a finished conversion |
| sda_oe_o | output | 1 | High pulls the data line low |
| div_sel_o | output | 8 | Divider select register |
| ctrl_o | output | 8 | Control register (upper four bits zero) |
| tune_o | output | 8 | Tuning offset register |

## Verification
The bench builds the block with two synchronizer stages and the default address base. It holds each SCL phase for ten system clocks, so every synchronized edge settles well inside a bus quarter-period. The strap input is switched mid-run, which covers both address values and the rejection of the other value. A conversion strobe arrives between the two temperature bytes, so the snapshot rule can be observed at the bus.

// File: rtl/cmdslv_pkg.sv
package cmdslv_pkg;

  localparam int BYTE_W = 8;

  localparam logic [7:0] CMD_DIV  = 8'h5D;
  localparam logic [7:0] CMD_CTRL = 8'h60;
  localparam logic [7:0] CMD_TEMP = 8'h64;
  localparam logic [7:0] CMD_TUNE = 8'h66;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDAT,
    ST_RDAT
  } link_st_e;

  function automatic logic cmd_known(input logic [7:0] c);
    return (c == CMD_DIV) || (c == CMD_CTRL) || (c == CMD_TEMP) || (c == CMD_TUNE);
  endfunction

endpackage

// File: rtl/cmdslv_sync.sv
module cmdslv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

  // R10: a bus condition is only ever reported while SCL was already high
  a_r10_cond_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |-> $past(scl_s));

endmodule

// File: rtl/cmdslv_link.sv
module cmdslv_link
  import cmdslv_pkg::*;
#(
  parameter logic [5:0] ADDR_BASE = 6'b100010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       strap_i,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic [7:0] cmd_o,
  output logic [1:0] rd_idx,
  output logic       rd_first
);

  link_st_e   st;
  logic [3:0] cnt;
  logic       ack_ph;
  logic [7:0] sh;
  logic       rw_q;
  logic [7:0] cmd_q;
  logic       oe_q;
  logic       mack_q;
  logic [1:0] idx_q;
  logic       bus_evt;

  assign bus_evt  = start_evt | stop_evt;
  assign sda_oe   = oe_q;
  assign cmd_o    = cmd_q;
  assign rd_idx   = idx_q;
  assign rd_first = !bus_evt && (st == ST_ADDR) && ack_ph && scl_fall && rw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      ack_ph  <= 1'b0;
      sh      <= '0;
      rw_q    <= 1'b0;
      cmd_q   <= '0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
      idx_q   <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        ack_ph <= 1'b0;
        oe_q   <= 1'b0;
      end else if (stop_evt) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        ack_ph <= 1'b0;
        oe_q   <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_CMD, ST_WDAT: begin
            if (scl_rise && !ack_ph && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end
            if (scl_fall) begin
              if (ack_ph) begin
                ack_ph <= 1'b0;
                oe_q   <= 1'b0;
                cnt    <= '0;
                if (st == ST_ADDR) begin
                  if (rw_q) begin
                    st   <= ST_RDAT;
                    sh   <= rd_byte;
                    oe_q <= ~rd_byte[7];
                  end else begin
                    st <= ST_CMD;
                  end
                end else if (st == ST_CMD) begin
                  st <= ST_WDAT;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (cnt == 4'd8) begin
                if (st == ST_ADDR) begin
                  if (sh[7:1] == {ADDR_BASE, strap_i}) begin
                    ack_ph <= 1'b1;
                    oe_q   <= 1'b1;
                    rw_q   <= sh[0];
                    idx_q  <= '0;
                  end else begin
                    st <= ST_IDLE;
                  end
                end else if (st == ST_CMD) begin
                  if (cmd_known(sh)) begin
                    ack_ph <= 1'b1;
                    oe_q   <= 1'b1;
                    cmd_q  <= sh;
                  end else begin
                    st <= ST_IDLE;
                  end
                end else begin
                  ack_ph  <= 1'b1;
                  oe_q    <= 1'b1;
                  wr_en   <= 1'b1;
                  wr_data <= sh;
                end
              end
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              if (cnt < 4'd9) cnt <= cnt + 4'd1;
              if (ack_ph) begin
                mack_q <= ~sda_s;
                if (!sda_s && idx_q != 2'd2) idx_q <= idx_q + 2'd1;
              end
            end
            if (scl_fall) begin
              if (ack_ph) begin
                ack_ph <= 1'b0;
                cnt    <= '0;
                if (mack_q) begin
                  sh   <= rd_byte;
                  oe_q <= ~rd_byte[7];
                end else begin
                  st   <= ST_IDLE;
                  oe_q <= 1'b0;
                end
              end else if (cnt == 4'd8) begin
                oe_q   <= 1'b0;
                ack_ph <= 1'b1;
              end else begin
                sh   <= {sh[6:0], 1'b0};
                oe_q <= ~sh[6];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: drive changes only with SCL low, apart from release on a bus condition
  a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(oe_q) && !$past(bus_evt)) |-> !scl_s);

  // R8: an idle link never pulls the line
  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !oe_q);

  // R3: while receiving, the line is pulled only during the acknowledge slot
  a_r3_ack_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && (st == ST_ADDR || st == ST_CMD || st == ST_WDAT)) |-> ack_ph);

  // R2: a write strobe always follows an accepted command
  a_r2_write_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cmd_known(cmd_q));

endmodule

// File: rtl/cmdslv_regs.sv
module cmdslv_regs
  import cmdslv_pkg::*;
#(
  parameter int CTRL_BITS = 4,
  parameter int TEMP_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           wr_data,
  input  logic [7:0]           cmd,
  input  logic [1:0]           rd_idx,
  input  logic                 rd_first,
  input  logic [TEMP_BITS-1:0] temp_code_i,
  input  logic                 temp_valid_i,
  output logic [7:0]           div_o,
  output logic [7:0]           ctrl_o,
  output logic [7:0]           tune_o,
  output logic [7:0]           rd_byte
);

  localparam int TEMP_W = 2 * BYTE_W;
  localparam int PAD_W  = TEMP_W - TEMP_BITS;

  logic [7:0]           div_q;
  logic [7:0]           tune_q;
  logic [CTRL_BITS-1:0] ctrl_q;
  logic [TEMP_W-1:0]    temp_hold;
  logic [7:0]           snap_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      tune_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      case (cmd)
        CMD_DIV:  div_q  <= wr_data;
        CMD_TUNE: tune_q <= wr_data;
        CMD_CTRL: ctrl_q <= wr_data[CTRL_BITS-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_hold <= '0;
      snap_lo   <= '0;
    end else begin
      if (temp_valid_i) temp_hold <= {temp_code_i, {PAD_W{1'b0}}};
      if (rd_first) snap_lo <= temp_hold[BYTE_W-1:0];
    end
  end

  generate
    if (CTRL_BITS < BYTE_W) begin : g_ctrl_pad
      assign ctrl_o = {{(BYTE_W-CTRL_BITS){1'b0}}, ctrl_q};
    end else begin : g_ctrl_full
      assign ctrl_o = ctrl_q;
    end
  endgenerate

  assign div_o  = div_q;
  assign tune_o = tune_q;

  always_comb begin
    rd_byte = 8'hFF;
    case (cmd)
      CMD_DIV:  if (rd_idx == 2'd0) rd_byte = div_q;
      CMD_CTRL: if (rd_idx == 2'd0) rd_byte = ctrl_o;
      CMD_TUNE: if (rd_idx == 2'd0) rd_byte = tune_q;
      CMD_TEMP: begin
        if (rd_idx == 2'd0)      rd_byte = temp_hold[TEMP_W-1:BYTE_W];
        else if (rd_idx == 2'd1) rd_byte = snap_lo;
      end
      default: ;
    endcase
  end

  // R3: the divider register moves only on a write strobe naming it
  a_r3_div_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_q) |-> $past(wr_en && cmd == CMD_DIV));

  // R7: the held temperature moves only on a conversion strobe
  a_r7_hold_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(temp_hold) |-> $past(temp_valid_i));

  // R6: the low-byte snapshot moves only when a read starts
  a_r6_snap_on_first: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap_lo) |-> $past(rd_first));

endmodule

// File: rtl/cmdslv_top.sv
module cmdslv_top
  import cmdslv_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_BASE   = 6'b100010,
  parameter int         CTRL_BITS   = 4,
  parameter int         TEMP_BITS   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 addr_strap_i,
  input  logic [TEMP_BITS-1:0] temp_code_i,
  input  logic                 temp_valid_i,
  output logic                 sda_oe_o,
  output logic [7:0]           div_sel_o,
  output logic [7:0]           ctrl_o,
  output logic [7:0]           tune_o
);

  logic       scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic       wr_en, rd_first;
  logic [7:0] wr_data, cmd, rd_byte;
  logic [1:0] rd_idx;

  cmdslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  cmdslv_link #(.ADDR_BASE(ADDR_BASE)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .strap_i   (addr_strap_i),
    .rd_byte   (rd_byte),
    .sda_oe    (sda_oe_o),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cmd_o     (cmd),
    .rd_idx    (rd_idx),
    .rd_first  (rd_first)
  );

  cmdslv_regs #(.CTRL_BITS(CTRL_BITS), .TEMP_BITS(TEMP_BITS)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .cmd          (cmd),
    .rd_idx       (rd_idx),
    .rd_first     (rd_first),
    .temp_code_i  (temp_code_i),
    .temp_valid_i (temp_valid_i),
    .div_o        (div_sel_o),
    .ctrl_o       (ctrl_o),
    .tune_o       (tune_o),
    .rd_byte      (rd_byte)
  );

endmodule

// File: tb/cmdslv_top_tb_top.sv
module cmdslv_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m, strap, tval;
  logic [9:0] tcode;
  logic       sda_oe;
  logic [7:0] div_sel, ctrl, tune;
  wire        sda_line = sda_m & ~sda_oe;
  int         n_vec = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  cmdslv_top dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .addr_strap_i (strap),
    .temp_code_i  (tcode),
    .temp_valid_i (tval),
    .sda_oe_o     (sda_oe),
    .div_sel_o    (div_sel),
    .ctrl_o       (ctrl),
    .tune_o       (tune)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (10) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bstop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic tx_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic rx_bit(output logic b);
    logic early;
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); early = sda_line; qw();
    b = sda_line;
    chk("R11 line steady while SCL high", {15'd0, b}, {15'd0, early});
    scl_m = 1'b0; qw();
  endtask

  task automatic tx_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) tx_bit(d[i]);
    rx_bit(b);
    ack = ~b;
  endtask

  task automatic rx_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rx_bit(b);
      d[i] = b;
    end
    tx_bit(~mack);
  endtask

  function automatic logic [7:0] adr(input logic rw);
    return {6'b100010, strap, rw};
  endfunction

  task automatic reg_write(input logic [7:0] c, input logic [7:0] d, input string tag);
    logic a;
    bstart();
    tx_byte(adr(1'b0), a); chk({tag, " address ack"}, {15'd0, a}, 16'd1);
    tx_byte(c, a);         chk({tag, " command ack"}, {15'd0, a}, 16'd1);
    tx_byte(d, a);         chk({tag, " data ack"}, {15'd0, a}, 16'd1);
    bstop();
  endtask

  task automatic reg_read(input logic [7:0] c, output logic [7:0] d);
    logic a;
    bstart();
    tx_byte(adr(1'b0), a); chk("R5 address ack", {15'd0, a}, 16'd1);
    tx_byte(c, a);         chk("R5 command ack", {15'd0, a}, 16'd1);
    bstart();
    tx_byte(adr(1'b1), a); chk("R1 read address ack", {15'd0, a}, 16'd1);
    rx_byte(d, 1'b0);
    chk("R8 released after NACK", {15'd0, sda_oe}, 16'd0);
    bstop();
  endtask

  task automatic t_reset();
    chk("R12 div reset", {8'd0, div_sel}, 16'd0);
    chk("R12 ctrl reset", {8'd0, ctrl}, 16'd0);
    chk("R12 tune reset", {8'd0, tune}, 16'd0);
    chk("R12 sda released", {15'd0, sda_oe}, 16'd0);
  endtask

  task automatic t_write_read();
    logic [7:0] d;
    logic       a;
    reg_write(8'h5D, 8'hA7, "R3 div");
    chk("R3 div output", {8'd0, div_sel}, 16'h00A7);
    reg_write(8'h66, 8'h83, "R3 tune");
    chk("R3 tune output", {8'd0, tune}, 16'h0083);
    reg_write(8'h60, 8'hFF, "R9 ctrl");
    chk("R9 ctrl upper bits zero", {8'd0, ctrl}, 16'h000F);
    reg_read(8'h5D, d); chk("R5 div readback", {8'd0, d}, 16'h00A7);
    reg_read(8'h60, d); chk("R9 ctrl readback", {8'd0, d}, 16'h000F);
    // pointer retained: second read with no new command, two bytes acked
    bstart();
    tx_byte(adr(1'b0), a);
    tx_byte(8'h66, a);
    bstart();
    tx_byte(adr(1'b1), a);
    rx_byte(d, 1'b1); chk("R5 tune first byte", {8'd0, d}, 16'h0083);
    rx_byte(d, 1'b0); chk("R5 second byte released", {8'd0, d}, 16'h00FF);
    bstop();
  endtask

  task automatic t_extra_byte();
    logic a;
    bstart();
    tx_byte(adr(1'b0), a);
    tx_byte(8'h5D, a);
    tx_byte(8'h11, a); chk("R4 first data ack", {15'd0, a}, 16'd1);
    tx_byte(8'h22, a); chk("R4 second data not acked", {15'd0, a}, 16'd0);
    bstop();
    chk("R4 register keeps first byte", {8'd0, div_sel}, 16'h0011);
  endtask

  task automatic t_address();
    logic a;
    strap = 1'b1;
    bstart();
    tx_byte({6'b100010, 1'b0, 1'b0}, a);
    chk("R1 other strap value rejected", {15'd0, a}, 16'd0);
    tx_byte(8'h5D, a);
    chk("R1 ignored until START", {15'd0, a}, 16'd0);
    bstop();
    reg_write(8'h66, 8'h3C, "R1 strap high");
    chk("R1 write with strap high", {8'd0, tune}, 16'h003C);
  endtask

  task automatic t_bad_cmd();
    logic a;
    bstart();
    tx_byte(adr(1'b0), a);
    tx_byte(8'h61, a); chk("R2 unknown command not acked", {15'd0, a}, 16'd0);
    tx_byte(8'h55, a); chk("R2 following byte not acked", {15'd0, a}, 16'd0);
    bstop();
    chk("R2 div untouched", {8'd0, div_sel}, 16'h0011);
    chk("R2 tune untouched", {8'd0, tune}, 16'h003C);
  endtask

  task automatic pulse_temp(input logic [9:0] c);
    @(negedge clk); tcode = c; tval = 1'b1;
    @(negedge clk); tval = 1'b0;
  endtask

  task automatic t_temperature();
    logic [7:0] d;
    logic       a;
    pulse_temp(10'h3FE);                 // -0.5 degrees
    bstart();
    tx_byte(adr(1'b0), a);
    tx_byte(8'h64, a); chk("R2 temp command ack", {15'd0, a}, 16'd1);
    bstart();
    tx_byte(adr(1'b1), a);
    rx_byte(d, 1'b1); chk("R6 temp MSB", {8'd0, d}, 16'h00FF);
    pulse_temp(10'h155);                 // new conversion between the bytes
    rx_byte(d, 1'b1); chk("R6 temp LSB from snapshot", {8'd0, d}, 16'h0080);
    rx_byte(d, 1'b0); chk("R6 third byte released", {8'd0, d}, 16'h00FF);
    bstop();
    reg_read(8'h64, d); chk("R6 new MSB", {8'd0, d}, 16'h0055);
    @(negedge clk); tcode = 10'h0AA;     // no strobe
    reg_read(8'h64, d); chk("R7 unstrobed code ignored", {8'd0, d}, 16'h0055);
    reg_write(8'h64, 8'h12, "R13 temp write");
    reg_read(8'h64, d); chk("R13 temp unaffected by write", {8'd0, d}, 16'h0055);
  endtask

  task automatic t_abort();
    logic a;
    bstart();
    for (int i = 0; i < 4; i++) tx_bit(1'b1);
    bstart();
    tx_byte(adr(1'b0), a); chk("R10 START mid-byte reframes", {15'd0, a}, 16'd1);
    tx_byte(8'h5D, a);
    for (int i = 0; i < 3; i++) tx_bit(1'b0);
    bstop();
    chk("R10 STOP mid-data keeps register", {8'd0, div_sel}, 16'h0011);
    reg_write(8'h5D, 8'h96, "R10 after abort");
    chk("R10 next write lands", {8'd0, div_sel}, 16'h0096);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 1'b0;
    tval = 1'b0; tcode = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_read();
    t_extra_byte();
    t_address();
    t_bad_cmd();
    t_temperature();
    t_abort();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule